// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single load or store and, when the indexing mode asks for it, the updated base value that goes back to the register file. The base comes either from a register or from the program counter; the offset is an immediate, a register, or a register passed through a shift or rotate. The offset is added to or taken from the base, and the indexing mode picks whether the access uses that result or the untouched base, and whether the result is written back.

Alongside the address the block produces per-byte lane enables for the data bus, honouring a little-endian or big-endian setting, and flags two illegal cases: a misaligned halfword or word, and a register offset taken from the program counter. Either flag cancels the writeback and clears the lane enables. All outputs are registered: a request presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `lsag_addr_gen`

## Requirements
- R1: After reset and whenever `req_valid` was low in the previous cycle, `out_valid`, `wb_en`, `lane_en`, `align_fault` and `illegal_ofs` are all zero; a request is reported on the outputs one clock after it is presented.
- R2: With `ofs_sel`=0 the offset is the zero-extended immediate: all 12 bits of `imm_ofs` for `acc_size` 0 (unsigned byte) and 2 (word), only the low 8 bits for `acc_size` 1 (halfword) and 3 (signed byte), the upper 4 bits being ignored.
- R3: With `ofs_sel`=1 the offset is `reg_ofs` unchanged; with `ofs_sel` 2 or 3 it is `reg_ofs` shifted by `shift_amt` per `shift_op`: 0 logical left, 1 logical right (amount 0 means 32, giving zero), 2 arithmetic right (amount 0 means 32, giving all sign bits), 3 rotate right (amount 0 means no rotation), 4 a one-bit right rotate through `shift_carry` entering at bit 31; codes 5 to 7 act as logical left.
- R4: `ofs_subtract`=1 subtracts the offset from the base (modulo 2^32); 0 adds it.
- R5: `idx_mode` 0 (and 3) is plain offset mode: `eff_addr` is base plus or minus offset and `wb_en` stays low.
- R6: `idx_mode` 1 is pre-indexed: `eff_addr` and `wb_data` both equal base plus or minus offset and `wb_en` is high.
- R7: `idx_mode` 2 is post-indexed: `eff_addr` is the unmodified base, `wb_data` is base plus or minus offset and `wb_en` is high.
- R8: When `base_is_pc` is high the base is `instr_addr` + 8 and `base_val` is ignored.
- R9: A register offset (`ofs_sel` nonzero) with `reg_ofs_is_pc` high raises `illegal_ofs`, forces `wb_en` low and `lane_en` to zero; with an immediate offset `reg_ofs_is_pc` has no effect.
- R10: A halfword whose `eff_addr` bit 0 is set, or a word whose `eff_addr` bits 1:0 are nonzero, raises `align_fault`, forces `wb_en` low and `lane_en` to zero; byte accesses never fault.
- R11: In little-endian mode (`big_endian`=0) lane k of `lane_en` carries byte address k within the word: a byte enables bit `eff_addr[1:0]`, a halfword enables 0011 or 1100 per `eff_addr[1]`, a word enables 1111.
- R12: In big-endian mode the lane pattern of R11 is mirrored, bit k taking the value of bit 3-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| instr_addr | input | 32 | Address of the current instruction |
| ofs_sel | input | 2 | Offset form: 0 immediate, 1 register, 2/3 shifted register |
| imm_ofs | input | 12 | Unsigned immediate offset |
| reg_ofs | input | 32 | Offset register value |
| reg_ofs_is_pc | input | 1 | Offset register is the program counter |
| shift_op | input | 3 | Shift kind for the shifted register form |
| shift_amt | input | 5 | Shift amount |
| shift_carry | input | 1 | Carry flag used by the one-bit rotate through carry |
| ofs_subtract | input | 1 | Subtract offset instead of adding it |
| idx_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as 0 |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 signed byte |
| big_endian | input | 1 | Big-endian lane ordering |
| out_valid | output | 1 | Outputs hold a result |
| eff_addr | output | 32 | Address used for the access |
| wb_data | output | 32 | Updated base value |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| lane_en | output | 4 | Per-byte data lane enables |
| align_fault | output | 1 | Halfword or word access is misaligned |
| illegal_ofs | output | 1 | Register offset taken from the program counter |

## Verification
The bench aims at the shift corner cases where an amount of zero changes meaning: a design that treated a right shift by zero as no shift would return the register instead of zero or sign fill, and a rotate through carry that dropped the carry would clear bit 31. It checks that the narrow immediate really discards its top bits for halfword and signed-byte accesses, that post-indexing addresses with the old base while pre-indexing uses the new one, and that the program counter base carries its +8 bias. Misaligned accesses, including a post-indexed one whose base is misaligned but whose updated value is aligned, must suppress writeback and lanes, and every aligned lane pattern is swept in both byte orders so a missing mirror or a wrong halfword lane pair shows up at once.

// File: rtl/lsag_pkg.sv
// Package lsag_pkg
// Shared encodings of the load/store address generator: offset forms,
// shift kinds, indexing modes and access sizes. Values are fixed because
// the instruction decoder upstream drives them directly.
package lsag_pkg;

    // offset form selector
    localparam logic [1:0] OFS_IMM    = 2'd0;
    localparam logic [1:0] OFS_REG    = 2'd1;

    // shift kinds for the shifted register offset
    localparam logic [2:0] SH_LSL     = 3'd0;
    localparam logic [2:0] SH_LSR     = 3'd1;
    localparam logic [2:0] SH_ASR     = 3'd2;
    localparam logic [2:0] SH_ROR     = 3'd3;
    localparam logic [2:0] SH_RRX     = 3'd4;

    // indexing modes
    localparam logic [1:0] IDX_OFFSET = 2'd0;
    localparam logic [1:0] IDX_PRE    = 2'd1;
    localparam logic [1:0] IDX_POST   = 2'd2;

    // access sizes
    localparam logic [1:0] SZ_BYTE    = 2'd0;
    localparam logic [1:0] SZ_HALF    = 2'd1;
    localparam logic [1:0] SZ_WORD    = 2'd2;
    localparam logic [1:0] SZ_SBYTE   = 2'd3;

endpackage

// File: rtl/lsag_offset.sv
// Module lsag_offset
// Builds the offset operand: a zero-extended immediate of wide or narrow
// width, the raw offset register, or that register passed through a
// shift/rotate. Purely combinational.
// Assumes W is at least IMM_WIDE and that shift_amt covers 0..W-1.
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int W          = 32,
    parameter int IMM_WIDE   = 12,
    parameter int IMM_NARROW = 8,
    localparam int SW        = $clog2(W)
) (
    input  logic [1:0]          ofs_sel,
    input  logic [IMM_WIDE-1:0] imm,
    input  logic                narrow,
    input  logic [W-1:0]        reg_val,
    input  logic [2:0]          shift_op,
    input  logic [SW-1:0]       shift_amt,
    input  logic                carry_in,
    output logic [W-1:0]        ofs
);

    logic [W-1:0]   imm_ext;
    logic [W-1:0]   shifted;
    logic [2*W-1:0] rot_pair;
    logic           amt_zero;

    // widen the immediate according to the access size
    always_comb begin
        if (narrow)
            imm_ext = {{(W-IMM_NARROW){1'b0}}, imm[IMM_NARROW-1:0]};
        else
            imm_ext = {{(W-IMM_WIDE){1'b0}}, imm};
    end

    assign amt_zero = (shift_amt == '0);
    assign rot_pair = {reg_val, reg_val} >> shift_amt;

    // barrel shifter over the five shift kinds, amount 0 special cases
    always_comb begin
        case (shift_op)
            SH_LSR:  shifted = amt_zero ? '0 : (reg_val >> shift_amt);
            SH_ASR:  shifted = amt_zero ? {W{reg_val[W-1]}}
                                        : W'($signed(reg_val) >>> shift_amt);
            SH_ROR:  shifted = rot_pair[W-1:0];
            SH_RRX:  shifted = {carry_in, reg_val[W-1:1]};
            default: shifted = reg_val << shift_amt;
        endcase
    end

    // pick the operand form
    always_comb begin
        case (ofs_sel)
            OFS_IMM: ofs = imm_ext;
            OFS_REG: ofs = reg_val;
            default: ofs = shifted;
        endcase
    end

endmodule

// File: rtl/lsag_lanes.sv
// Module lsag_lanes
// Checks natural alignment of the access and produces byte-lane enables,
// mirrored for big-endian ordering. Purely combinational.
// Assumes a word spans W/8 lanes and a halfword two lanes.
module lsag_lanes
    import lsag_pkg::*;
#(
    parameter int W      = 32,
    localparam int LANES = W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  logic [LB-1:0]    addr_lo,
    input  logic [1:0]       size,
    input  logic             big_endian,
    output logic [LANES-1:0] lanes,
    output logic             misaligned
);

    logic [LANES-1:0] lanes_le;

    // little-endian lane pattern and alignment check per size
    always_comb begin
        case (size)
            SZ_HALF: begin
                misaligned = addr_lo[0];
                lanes_le   = LANES'(2'b11) << {addr_lo[LB-1:1], 1'b0};
            end
            SZ_WORD: begin
                misaligned = |addr_lo;
                lanes_le   = '1;
            end
            default: begin
                misaligned = 1'b0;
                lanes_le   = LANES'(1) << addr_lo;
            end
        endcase
    end

    // mirror lanes for big-endian ordering
    for (genvar g = 0; g < LANES; g++) begin : g_mirror
        assign lanes[g] = big_endian ? lanes_le[LANES-1-g] : lanes_le[g];
    end

endmodule

// File: rtl/lsag_addr_gen.sv
// Module lsag_addr_gen
// Effective address generator for single loads and stores. Chooses the
// base (register or biased program counter), adds or subtracts the offset,
// applies the indexing mode, and registers address, writeback value,
// lane enables and fault flags. One cycle latency, synchronous active-low
// reset. Assumes the register file and memory access live elsewhere.
module lsag_addr_gen
    import lsag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_BIAS    = 8,
    parameter int IMM_WIDE   = 12,
    parameter int IMM_NARROW = 8,
    localparam int AMT_W     = $clog2(ADDR_W),
    localparam int LANES     = ADDR_W / 8,
    localparam int LB        = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic                base_is_pc,
    input  logic [ADDR_W-1:0]   instr_addr,
    input  logic [1:0]          ofs_sel,
    input  logic [IMM_WIDE-1:0] imm_ofs,
    input  logic [ADDR_W-1:0]   reg_ofs,
    input  logic                reg_ofs_is_pc,
    input  logic [2:0]          shift_op,
    input  logic [AMT_W-1:0]    shift_amt,
    input  logic                shift_carry,
    input  logic                ofs_subtract,
    input  logic [1:0]          idx_mode,
    input  logic [1:0]          acc_size,
    input  logic                big_endian,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [ADDR_W-1:0]   wb_data,
    output logic                wb_en,
    output logic [LANES-1:0]    lane_en,
    output logic                align_fault,
    output logic                illegal_ofs
);

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] moved;
    logic [ADDR_W-1:0] ea_next;
    logic [LANES-1:0]  lanes_next;
    logic              narrow_imm;
    logic              wants_wb;
    logic              mis_next;
    logic              ill_next;
    logic              kill;
    logic [1:0]        mode_q;
    logic [1:0]        size_q;

    assign narrow_imm = (acc_size == SZ_HALF) || (acc_size == SZ_SBYTE);

    lsag_offset #(
        .W          (ADDR_W),
        .IMM_WIDE   (IMM_WIDE),
        .IMM_NARROW (IMM_NARROW)
    ) u_offset (
        .ofs_sel   (ofs_sel),
        .imm       (imm_ofs),
        .narrow    (narrow_imm),
        .reg_val   (reg_ofs),
        .shift_op  (shift_op),
        .shift_amt (shift_amt),
        .carry_in  (shift_carry),
        .ofs       (ofs)
    );

    // base selection and offset arithmetic
    always_comb begin
        base_eff = base_is_pc ? (instr_addr + ADDR_W'(PC_BIAS)) : base_val;
        moved    = ofs_subtract ? (base_eff - ofs) : (base_eff + ofs);
        ea_next  = (idx_mode == IDX_POST) ? base_eff : moved;
        wants_wb = (idx_mode == IDX_PRE) || (idx_mode == IDX_POST);
        ill_next = (ofs_sel != OFS_IMM) && reg_ofs_is_pc;
    end

    lsag_lanes #(
        .W (ADDR_W)
    ) u_lanes (
        .addr_lo    (ea_next[LB-1:0]),
        .size       (acc_size),
        .big_endian (big_endian),
        .lanes      (lanes_next),
        .misaligned (mis_next)
    );

    assign kill = mis_next || ill_next;

    // output register stage with fault gating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            eff_addr    <= '0;
            wb_data     <= '0;
            wb_en       <= 1'b0;
            lane_en     <= '0;
            align_fault <= 1'b0;
            illegal_ofs <= 1'b0;
            mode_q      <= IDX_OFFSET;
            size_q      <= SZ_BYTE;
        end else begin
            out_valid   <= req_valid;
            eff_addr    <= ea_next;
            wb_data     <= moved;
            wb_en       <= req_valid && wants_wb && !kill;
            lane_en     <= (req_valid && !kill) ? lanes_next : '0;
            align_fault <= req_valid && mis_next;
            illegal_ofs <= req_valid && ill_next;
            mode_q      <= idx_mode;
            size_q      <= acc_size;
        end
    end

    // R1: nothing is reported without a request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wb_en && lane_en == '0 && !align_fault && !illegal_ofs));

    // R5: plain offset mode never writes back
    a_r5_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == IDX_OFFSET) |-> !wb_en);

    // R6: pre-indexed writeback equals the access address
    a_r6_pre_wb_is_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && mode_q == IDX_PRE) |-> (wb_data == eff_addr));

    // R9: illegal register offset blocks writeback and lanes
    a_r9_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_ofs |-> (!wb_en && lane_en == '0));

    // R10: alignment fault blocks writeback and lanes
    a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!wb_en && lane_en == '0));

    // R11: clean accesses enable exactly as many lanes as bytes moved
    a_r11_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !align_fault && !illegal_ofs) |->
        ($countones(lane_en) ==
         ((size_q == SZ_WORD) ? LANES : (size_q == SZ_HALF) ? 2 : 1)));

endmodule

// File: tb/test_lsag_addr_gen.sv
// Directed bench for lsag_addr_gen: one task per scenario, each comparing
// the registered outputs against a model computed from the requirements.
module test_lsag_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] base_val;
    logic        base_is_pc;
    logic [31:0] instr_addr;
    logic [1:0]  ofs_sel;
    logic [11:0] imm_ofs;
    logic [31:0] reg_ofs;
    logic        reg_ofs_is_pc;
    logic [2:0]  shift_op;
    logic [4:0]  shift_amt;
    logic        shift_carry;
    logic        ofs_subtract;
    logic [1:0]  idx_mode;
    logic [1:0]  acc_size;
    logic        big_endian;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] wb_data;
    logic        wb_en;
    logic [3:0]  lane_en;
    logic        align_fault;
    logic        illegal_ofs;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lsag_addr_gen i_lsag_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_val(base_val), .base_is_pc(base_is_pc), .instr_addr(instr_addr),
        .ofs_sel(ofs_sel), .imm_ofs(imm_ofs), .reg_ofs(reg_ofs),
        .reg_ofs_is_pc(reg_ofs_is_pc), .shift_op(shift_op),
        .shift_amt(shift_amt), .shift_carry(shift_carry),
        .ofs_subtract(ofs_subtract), .idx_mode(idx_mode),
        .acc_size(acc_size), .big_endian(big_endian),
        .out_valid(out_valid), .eff_addr(eff_addr), .wb_data(wb_data),
        .wb_en(wb_en), .lane_en(lane_en), .align_fault(align_fault),
        .illegal_ofs(illegal_ofs)
    );

    task automatic defaults();
        req_valid = 1'b1; base_val = 32'h0000_1000; base_is_pc = 1'b0;
        instr_addr = 32'h0000_8000; ofs_sel = 2'd0; imm_ofs = 12'h000;
        reg_ofs = 32'h0; reg_ofs_is_pc = 1'b0; shift_op = 3'd0;
        shift_amt = 5'd0; shift_carry = 1'b0; ofs_subtract = 1'b0;
        idx_mode = 2'd0; acc_size = 2'd2; big_endian = 1'b0;
    endtask

    task automatic cmp(input string tag, input string field,
                       input logic [31:0] act, input logic [31:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
            bad = 1'b1;
        end
    endtask

    // apply current inputs, compute the model, compare one cycle later
    task automatic run(input string tag);
        logic [31:0] b, o, r, sum, e_ea;
        logic [3:0]  le, e_lanes;
        logic        mis, ill, e_wbe, narrow;
        bit          bad = 1'b0;
        b = base_is_pc ? instr_addr + 32'd8 : base_val;
        narrow = (acc_size == 2'd1) || (acc_size == 2'd3);
        r = reg_ofs;
        if (ofs_sel == 2'd0)      o = narrow ? {24'h0, imm_ofs[7:0]} : {20'h0, imm_ofs};
        else if (ofs_sel == 2'd1) o = r;
        else begin
            case (shift_op)
                3'd1: o = (shift_amt == 0) ? 32'h0 : r >> shift_amt;
                3'd2: o = (shift_amt == 0) ? {32{r[31]}} : 32'($signed(r) >>> shift_amt);
                3'd3: o = (shift_amt == 0) ? r : (r >> shift_amt) | (r << (6'd32 - shift_amt));
                3'd4: o = {shift_carry, r[31:1]};
                default: o = r << shift_amt;
            endcase
        end
        sum  = ofs_subtract ? b - o : b + o;
        e_ea = (idx_mode == 2'd2) ? b : sum;
        ill  = (ofs_sel != 2'd0) && reg_ofs_is_pc;
        mis  = (acc_size == 2'd1) ? e_ea[0] : (acc_size == 2'd2) ? (e_ea[1:0] != 0) : 1'b0;
        case (acc_size)
            2'd1:    le = e_ea[1] ? 4'b1100 : 4'b0011;
            2'd2:    le = 4'b1111;
            default: le = 4'b0001 << e_ea[1:0];
        endcase
        if (big_endian) le = {le[0], le[1], le[2], le[3]};
        e_lanes = (ill || mis || !req_valid) ? 4'h0 : le;
        e_wbe   = req_valid && (idx_mode == 2'd1 || idx_mode == 2'd2) && !ill && !mis;
        @(posedge clk);
        @(negedge clk);
        vecs++;
        cmp(tag, "out_valid", 32'(out_valid), 32'(req_valid), bad);
        cmp(tag, "wb_en", 32'(wb_en), 32'(e_wbe), bad);
        cmp(tag, "lane_en", 32'(lane_en), 32'(e_lanes), bad);
        cmp(tag, "align_fault", 32'(align_fault), 32'(req_valid && mis), bad);
        cmp(tag, "illegal_ofs", 32'(illegal_ofs), 32'(req_valid && ill), bad);
        if (req_valid) begin
            cmp(tag, "eff_addr", eff_addr, e_ea, bad);
            if (e_wbe) cmp(tag, "wb_data", wb_data, sum, bad);
        end
        if (bad) fails++;
    endtask

    task automatic t_reset();   // R1
        bit bad = 1'b0;
        vecs++;
        cmp("R1", "out_valid", 32'(out_valid), 0, bad);
        cmp("R1", "wb_en", 32'(wb_en), 0, bad);
        cmp("R1", "lane_en", 32'(lane_en), 0, bad);
        cmp("R1", "align_fault", 32'(align_fault), 0, bad);
        cmp("R1", "illegal_ofs", 32'(illegal_ofs), 0, bad);
        if (bad) fails++;
        defaults(); req_valid = 1'b0; idx_mode = 2'd1; acc_size = 2'd1;
        base_val = 32'h101;                  // idle cycle must stay quiet
        run("R1");
    endtask

    task automatic t_imm();     // R2
        defaults(); imm_ofs = 12'hFFC; run("R2");
        defaults(); imm_ofs = 12'hF3E; acc_size = 2'd1; run("R2");
        defaults(); imm_ofs = 12'hA13; acc_size = 2'd3; run("R2");
        defaults(); imm_ofs = 12'hFFF; acc_size = 2'd0; run("R2");
    endtask

    task automatic t_shift();   // R3
        defaults(); ofs_sel = 2'd1; reg_ofs = 32'h40; shift_op = 3'd1; shift_amt = 5'd4; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h11; shift_op = 3'd0; shift_amt = 5'd2; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'hF00; shift_op = 3'd1; shift_amt = 5'd4; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'hFFFF_FF00; shift_op = 3'd1; shift_amt = 5'd0; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h8000_0000; shift_op = 3'd2; shift_amt = 5'd0; run("R3");
        defaults(); ofs_sel = 2'd3; reg_ofs = 32'hF000_0040; shift_op = 3'd2; shift_amt = 5'd4; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h0000_0C44; shift_op = 3'd3; shift_amt = 5'd8; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h0000_0028; shift_op = 3'd3; shift_amt = 5'd0; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h0000_0008; shift_op = 3'd4; shift_carry = 1'b1; run("R3");
        defaults(); ofs_sel = 2'd2; reg_ofs = 32'h0000_0003; shift_op = 3'd6; shift_amt = 5'd2; run("R3");
    endtask

    task automatic t_sub();     // R4
        defaults(); imm_ofs = 12'h010; ofs_subtract = 1'b1; run("R4");
        defaults(); base_val = 32'h4; imm_ofs = 12'h008; ofs_subtract = 1'b1; run("R4");
    endtask

    task automatic t_modes();   // R5 R6 R7
        defaults(); imm_ofs = 12'h024; idx_mode = 2'd0; run("R5");
        defaults(); imm_ofs = 12'h024; idx_mode = 2'd3; run("R5");
        defaults(); imm_ofs = 12'h024; idx_mode = 2'd1; run("R6");
        defaults(); imm_ofs = 12'h024; idx_mode = 2'd2; run("R7");
        defaults(); ofs_sel = 2'd1; reg_ofs = 32'h100; ofs_subtract = 1'b1; idx_mode = 2'd2; run("R7");
    endtask

    task automatic t_pc();      // R8
        defaults(); base_is_pc = 1'b1; base_val = 32'hDEAD_BEE0; imm_ofs = 12'h040; run("R8");
        defaults(); base_is_pc = 1'b1; instr_addr = 32'h0000_0200; ofs_subtract = 1'b1;
        imm_ofs = 12'h00C; run("R8");
    endtask

    task automatic t_pcofs();   // R9
        defaults(); ofs_sel = 2'd1; reg_ofs_is_pc = 1'b1; reg_ofs = 32'h8; idx_mode = 2'd1; run("R9");
        defaults(); ofs_sel = 2'd2; reg_ofs_is_pc = 1'b1; reg_ofs = 32'h8; shift_amt = 5'd1; run("R9");
        defaults(); ofs_sel = 2'd0; reg_ofs_is_pc = 1'b1; imm_ofs = 12'h8; idx_mode = 2'd1; run("R9");
    endtask

    task automatic t_align();   // R10
        defaults(); acc_size = 2'd1; imm_ofs = 12'h003; idx_mode = 2'd1; run("R10");
        defaults(); acc_size = 2'd2; imm_ofs = 12'h002; idx_mode = 2'd1; run("R10");
        defaults(); acc_size = 2'd2; base_val = 32'h1002; imm_ofs = 12'h002; idx_mode = 2'd2; run("R10");
        defaults(); acc_size = 2'd0; imm_ofs = 12'h003; idx_mode = 2'd1; run("R10");
        defaults(); acc_size = 2'd3; imm_ofs = 12'h001; idx_mode = 2'd1; run("R10");
    endtask

    task automatic t_lanes();   // R11 R12
        for (int be = 0; be < 2; be++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int a = 0; a < 4; a++) begin
                    defaults(); big_endian = be[0]; acc_size = sz[1:0];
                    imm_ofs = 12'(a);
                    if ((sz == 1 && a[0]) || (sz == 2 && a != 0)) continue;
                    run(be ? "R12" : "R11");
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        defaults();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_imm();
        t_shift();
        t_sub();
        t_modes();
        t_pc();
        t_pcofs();
        t_align();
        t_lanes();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule